// File: doc/BRIEF.md
# Multi-cluster CPU reset controller

This block owns the reset lines of a processor complex made of several clusters. Each cluster has four cores. Every core has three lines: the core itself, its SIMD unit and its debug logic. Every cluster also has two shared lines: the L2 cache and the cluster debug logic. All outputs are active-high and mean "held in reset". Software controls the lines through a simple single-cycle register bus. Each cluster has three registers: a set register, where a 1 bit puts a line into reset, a clear register, where a 1 bit releases a line, and a status word.

A write does not take effect on the lines at once. The new value reaches the outputs after a fixed number of cycles, `RELEASE_LATENCY`. Software therefore polls the status word until it shows the change it asked for. The status word shows the line state in the same bit positions as the control registers. It also shows each core's wait-for-interrupt, wait-for-event and debug-acknowledge inputs. After system reset, only core 0 of cluster 0 and the shared lines of cluster 0 are released, so that one boot core runs. Every other line starts in reset.

Top module: `cluster_reset_ctrl`

## Requirements
- R1: During and right after the synchronous reset `rst`, every line is in reset, with five exceptions in cluster 0: the core, SIMD and core-debug lines of core 0, the L2 line and the cluster debug line are released. `bus_rdata` is 0.
- R2: A write to byte address 0x520 + 8n, for cluster n below `NUM_CLUSTERS`, puts a line into reset for each 1 bit in `bus_wdata`. Lines whose bit is 0 keep their state.
- R3: A write to byte address 0x524 + 8n releases a line for each 1 bit in `bus_wdata`. Lines whose bit is 0 keep their state.
- R4: Control bit positions are as follows:
  - core x reset is bit x;
  - SIMD x reset is bit x+4;
  - core-debug x reset is bit x+9;
  - L2 reset is bit 8;
  - cluster debug reset is bit 13.
  
  Written bits 14 to 31 have no effect. Outputs are indexed as [4n+x] per core and [n] per cluster.
- R5: A write accepted at clock edge E changes the reset outputs at edge E + `RELEASE_LATENCY` (default 4), and not before.
- R6: Reading 0x1520 + 8n returns the current line state of cluster n in bits 0 to 13, where 1 means in reset. `bus_rdata` is registered: it is valid after the edge that samples `bus_addr`.
- R7: Status bits 16+x, 20+x and 24+x show the wait-for-interrupt, wait-for-event and debug-acknowledge inputs of core x, as sampled at that edge. Bits 14, 15 and 28 to 31 read 0.
- R8: Reads of the set and clear addresses, of any unmapped address and of cluster indices at or above `NUM_CLUSTERS` return 0. Writes to those unmapped addresses and to status addresses change no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| core_wfi | input | 16 | Per-core wait-for-interrupt flag, index 4n+x |
| core_wfe | input | 16 | Per-core wait-for-event flag |
| core_dbg_ack | input | 16 | Per-core debug acknowledge |
| core_rst_o | output | 16 | Core reset, index 4n+x |
| simd_rst_o | output | 16 | SIMD unit reset |
| cdbg_rst_o | output | 16 | Core debug reset |
| l2_rst_o | output | 4 | Cluster L2 reset |
| cldbg_rst_o | output | 4 | Cluster debug reset |

## Verification
A write sampled at edge E is expected on the line outputs only after edge E + `RELEASE_LATENCY`, and read data for an address driven before edge E is expected just after E. The bench keeps a model of each cluster's target state and its `RELEASE_LATENCY` older values. The model advances once per edge. The bench drives on the falling edge, and after every rising edge it compares every reset output and `bus_rdata` on the next falling edge. Each check therefore falls in the exact cycle a change is due: a line that moves early or late is a miscompare.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int CTRL_W      = 14;
  localparam int CORES       = 4;
  localparam int SIMD_OFS    = 4;
  localparam int L2_BIT      = 8;
  localparam int CDBG_OFS    = 9;
  localparam int CLDBG_BIT   = 13;
  localparam int WFI_OFS     = 16;
  localparam int WFE_OFS     = 20;
  localparam int ACK_OFS     = 24;
  localparam int SET_BASE    = 'h0520;
  localparam int CLR_BASE    = 'h0524;
  localparam int STAT_BASE   = 'h1520;
  localparam int STRIDE      = 8;

  typedef logic [CTRL_W-1:0] ctrl_word_t;

  // Power-on line state: cluster 0 keeps core 0 and its shared lines running.
  function automatic ctrl_word_t boot_word(input int idx);
    ctrl_word_t w;
    w = '1;
    if (idx == 0) begin
      w[0]           = 1'b0;
      w[SIMD_OFS]    = 1'b0;
      w[CDBG_OFS]    = 1'b0;
      w[L2_BIT]      = 1'b0;
      w[CLDBG_BIT]   = 1'b0;
    end
    return w;
  endfunction
endpackage

// File: rtl/crc_decoder.sv
module crc_decoder
  import crc_pkg::*;
#(
  parameter int NUM_CLUSTERS = 4,
  parameter int ADDR_W       = 16
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr,
  output logic [NUM_CLUSTERS-1:0] set_en,
  output logic [NUM_CLUSTERS-1:0] clr_en,
  output logic [NUM_CLUSTERS-1:0] stat_sel
);
  for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_dec
    localparam logic [ADDR_W-1:0] SetA  = ADDR_W'(SET_BASE  + c * STRIDE);
    localparam logic [ADDR_W-1:0] ClrA  = ADDR_W'(CLR_BASE  + c * STRIDE);
    localparam logic [ADDR_W-1:0] StatA = ADDR_W'(STAT_BASE + c * STRIDE);
    assign set_en[c]   = wr && (addr == SetA);
    assign clr_en[c]   = wr && (addr == ClrA);
    assign stat_sel[c] = (addr == StatA);
  end

  // R8: a status access never reaches the control path
  always_comb begin
    a_r8_status_write_inert: assert (!(|stat_sel) || ((set_en | clr_en) == '0));
  end
endmodule

// File: rtl/crc_cluster.sv
module crc_cluster
  import crc_pkg::*;
#(
  parameter int CL_IDX          = 0,
  parameter int RELEASE_LATENCY = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_en,
  input  logic       clr_en,
  input  ctrl_word_t wdata,
  output ctrl_word_t lines
);
  localparam int         LAT  = RELEASE_LATENCY;
  localparam int         CW   = $clog2(LAT + 1);
  localparam ctrl_word_t BOOT = boot_word(CL_IDX);

  ctrl_word_t target;
  ctrl_word_t stage [1:LAT];

  // The set path is applied last, so it wins over a release of the same bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      target <= BOOT;
    end else begin
      target <= ((target & ~(clr_en ? wdata : '0)) | (set_en ? wdata : '0));
    end
  end

  for (genvar k = 1; k <= LAT; k++) begin : g_pipe
    if (k == 1) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[k] <= BOOT;
        else     stage[k] <= target;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[k] <= BOOT;
        else     stage[k] <= stage[k-1];
      end
    end
  end

  assign lines = stage[LAT];

  // Cycles since the last accepted write, saturating at the latency.
  logic [CW-1:0] settle_cnt;
  always_ff @(posedge clk) begin
    if (rst)                        settle_cnt <= CW'(LAT);
    else if (set_en || clr_en)      settle_cnt <= '0;
    else if (settle_cnt != CW'(LAT)) settle_cnt <= settle_cnt + 1'b1;
  end

  a_r2_set_lands: assert property (@(posedge clk) disable iff (rst)
    set_en |=> ((target & $past(wdata)) == $past(wdata)));

  a_r3_clear_lands: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !set_en) |=> ((target & $past(wdata)) == '0));

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!set_en && !clr_en) |=> $stable(target));

  a_r5_lines_settle: assert property (@(posedge clk) disable iff (rst)
    (settle_cnt == CW'(LAT)) |-> (lines == target));
endmodule

// File: rtl/crc_status.sv
module crc_status
  import crc_pkg::*;
#(
  parameter int NUM_CLUSTERS = 4,
  parameter int DATA_W       = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_CLUSTERS-1:0]       stat_sel,
  input  ctrl_word_t                    lines [NUM_CLUSTERS],
  input  logic [NUM_CLUSTERS*CORES-1:0] wfi,
  input  logic [NUM_CLUSTERS*CORES-1:0] wfe,
  input  logic [NUM_CLUSTERS*CORES-1:0] dbg_ack,
  output logic [DATA_W-1:0]             rdata
);
  logic [DATA_W-1:0] word [NUM_CLUSTERS];
  logic [DATA_W-1:0] mux_out;

  for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_word
    always_comb begin
      word[c] = '0;
      word[c][CTRL_W-1:0]               = lines[c];
      word[c][WFI_OFS +: CORES]         = wfi[c*CORES +: CORES];
      word[c][WFE_OFS +: CORES]         = wfe[c*CORES +: CORES];
      word[c][ACK_OFS +: CORES]         = dbg_ack[c*CORES +: CORES];
    end
  end

  always_comb begin
    mux_out = '0;
    for (int c = 0; c < NUM_CLUSTERS; c++) begin
      if (stat_sel[c]) mux_out = mux_out | word[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mux_out;
  end

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rdata[15:14] == 2'b00) && (rdata[DATA_W-1:28] == '0));

  a_r8_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (stat_sel == '0) |=> (rdata == '0));
endmodule

// File: rtl/cluster_reset_ctrl.sv
module cluster_reset_ctrl
  import crc_pkg::*;
#(
  parameter int NUM_CLUSTERS    = 4,
  parameter int ADDR_W          = 16,
  parameter int DATA_W          = 32,
  parameter int RELEASE_LATENCY = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_wr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  input  logic [NUM_CLUSTERS*CORES-1:0] core_wfi,
  input  logic [NUM_CLUSTERS*CORES-1:0] core_wfe,
  input  logic [NUM_CLUSTERS*CORES-1:0] core_dbg_ack,
  output logic [NUM_CLUSTERS*CORES-1:0] core_rst_o,
  output logic [NUM_CLUSTERS*CORES-1:0] simd_rst_o,
  output logic [NUM_CLUSTERS*CORES-1:0] cdbg_rst_o,
  output logic [NUM_CLUSTERS-1:0]       l2_rst_o,
  output logic [NUM_CLUSTERS-1:0]       cldbg_rst_o
);
  logic [NUM_CLUSTERS-1:0] set_en, clr_en, stat_sel;
  ctrl_word_t              lines [NUM_CLUSTERS];
  ctrl_word_t              wbits;

  assign wbits = bus_wdata[CTRL_W-1:0];

  crc_decoder #(
    .NUM_CLUSTERS (NUM_CLUSTERS),
    .ADDR_W       (ADDR_W)
  ) dec_i (
    .addr     (bus_addr),
    .wr       (bus_wr),
    .set_en   (set_en),
    .clr_en   (clr_en),
    .stat_sel (stat_sel)
  );

  for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_cl
    crc_cluster #(
      .CL_IDX          (c),
      .RELEASE_LATENCY (RELEASE_LATENCY)
    ) cl_i (
      .clk    (clk),
      .rst    (rst),
      .set_en (set_en[c]),
      .clr_en (clr_en[c]),
      .wdata  (wbits),
      .lines  (lines[c])
    );

    for (genvar x = 0; x < CORES; x++) begin : g_core
      assign core_rst_o[c*CORES + x] = lines[c][x];
      assign simd_rst_o[c*CORES + x] = lines[c][SIMD_OFS + x];
      assign cdbg_rst_o[c*CORES + x] = lines[c][CDBG_OFS + x];
    end
    assign l2_rst_o[c]    = lines[c][L2_BIT];
    assign cldbg_rst_o[c] = lines[c][CLDBG_BIT];
  end

  crc_status #(
    .NUM_CLUSTERS (NUM_CLUSTERS),
    .DATA_W       (DATA_W)
  ) stat_i (
    .clk      (clk),
    .rst      (rst),
    .stat_sel (stat_sel),
    .lines    (lines),
    .wfi      (core_wfi),
    .wfe      (core_wfe),
    .dbg_ack  (core_dbg_ack),
    .rdata    (bus_rdata)
  );

  // R8: one bus access selects at most one register
  a_r8_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({set_en, clr_en, stat_sel}));
endmodule

// File: tb/cluster_reset_ctrl_tb_top.sv
module cluster_reset_ctrl_tb_top;
  localparam int NC  = 4;
  localparam int NCR = 4;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NC*NCR-1:0] core_wfi = '0, core_wfe = '0, core_dbg_ack = '0;
  logic [NC*NCR-1:0] core_rst_o, simd_rst_o, cdbg_rst_o;
  logic [NC-1:0]     l2_rst_o, cldbg_rst_o;

  always #5 clk = ~clk;

  cluster_reset_ctrl #(
    .NUM_CLUSTERS (NC),
    .RELEASE_LATENCY (LAT)
  ) dut_i (
    .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_wr (bus_wr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .core_wfi (core_wfi), .core_wfe (core_wfe), .core_dbg_ack (core_dbg_ack),
    .core_rst_o (core_rst_o), .simd_rst_o (simd_rst_o), .cdbg_rst_o (cdbg_rst_o),
    .l2_rst_o (l2_rst_o), .cldbg_rst_o (cldbg_rst_o)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // hist[c][0] is the target after the latest edge, hist[c][LAT] the lines.
  logic [13:0] hist [NC][LAT+1];

  function automatic logic [13:0] boot_val(int c);
    return (c == 0) ? 14'h1CEE : 14'h3FFF;
  endfunction

  function automatic logic [63:0] exp_lines();
    logic [NCR*NC-1:0] cr, sm, cd;
    logic [NC-1:0] l2, cl;
    for (int c = 0; c < NC; c++) begin
      for (int x = 0; x < NCR; x++) begin
        cr[c*NCR+x] = hist[c][LAT][x];
        sm[c*NCR+x] = hist[c][LAT][x+4];
        cd[c*NCR+x] = hist[c][LAT][x+9];
      end
      l2[c] = hist[c][LAT][8];
      cl[c] = hist[c][LAT][13];
    end
    return {8'h0, cr, sm, cd, l2, cl};
  endfunction

  function automatic logic [31:0] exp_read(logic [15:0] a);
    logic [31:0] w = '0;
    for (int c = 0; c < NC; c++) begin
      if (a == 16'(32'h1520 + 8*c)) begin
        w[13:0]  = hist[c][LAT];
        w[19:16] = core_wfi[c*NCR +: NCR];
        w[23:20] = core_wfe[c*NCR +: NCR];
        w[27:24] = core_dbg_ack[c*NCR +: NCR];
      end
    end
    return w;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [15:0] a, logic w, logic [31:0] d, string tag);
    logic [31:0] er;
    bus_addr = a; bus_wr = w; bus_wdata = d;
    core_wfi = 16'($urandom); core_wfe = 16'($urandom); core_dbg_ack = 16'($urandom);
    er = exp_read(a);
    @(posedge clk);
    for (int c = 0; c < NC; c++) begin
      for (int i = LAT; i > 0; i--) hist[c][i] = hist[c][i-1];
      if (w && a == 16'(32'h0520 + 8*c)) hist[c][0] = hist[c][0] | d[13:0];
      if (w && a == 16'(32'h0524 + 8*c)) hist[c][0] = hist[c][0] & ~d[13:0];
    end
    @(negedge clk);
    bus_wr = 1'b0;
    check({tag, " lines"}, {8'h0, core_rst_o, simd_rst_o, cdbg_rst_o, l2_rst_o, cldbg_rst_o},
          exp_lines());
    check({tag, " R6/R7/R8 rdata"}, {32'h0, bus_rdata}, {32'h0, er});
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(16'h0000, 1'b0, 32'h0, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NC; c++)
      for (int i = 0; i <= LAT; i++) hist[c][i] = boot_val(c);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 boot lines", {8'h0, core_rst_o, simd_rst_o, cdbg_rst_o, l2_rst_o, cldbg_rst_o},
          exp_lines());
    check("R1 rdata", {32'h0, bus_rdata}, 64'h0);
    rst = 1'b0;

    // R3 + R5: release core 1 group of cluster 2, exact latency
    step(16'h0534, 1'b1, 32'h0000_0422, "R3");
    for (int i = 1; i < LAT; i++) begin
      step(16'h1530, 1'b0, 32'h0, "R5 before");
      check("R5 still held", {63'h0, simd_rst_o[9]}, 64'h1);
    end
    step(16'h1530, 1'b0, 32'h0, "R5 due");
    // R4: bit positions map to core 1 of cluster 2
    check("R4 core", {63'h0, core_rst_o[9]}, 64'h0);
    check("R4 simd", {63'h0, simd_rst_o[9]}, 64'h0);
    check("R4 cdbg", {63'h0, cdbg_rst_o[9]}, 64'h0);
    check("R4 core0 held", {63'h0, core_rst_o[8]}, 64'h1);

    // R4: upper write bits ignored; R2 re-assert of cluster 0 L2 line
    step(16'h0520, 1'b1, 32'hFFFF_C000, "R4 high bits");
    step(16'h0520, 1'b1, 32'h0000_0100, "R2");
    idle(LAT, "R2 settle");
    check("R2 l2 cl0", {63'h0, l2_rst_o[0]}, 64'h1);
    check("R4 cl0 core0 kept", {63'h0, core_rst_o[0]}, 64'h0);

    // R8: unmapped cluster and status writes
    step(16'h0544, 1'b1, 32'h0000_3FFF, "R8 cluster4");
    step(16'h1520, 1'b1, 32'h0000_3FFF, "R8 status write");
    step(16'h0524, 1'b0, 32'h0, "R8 read clr");
    idle(LAT, "R8 settle");
    step(16'h1520, 1'b0, 32'h0, "R6 R7 status");

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      int op = int'($urandom % 8);
      int c  = int'($urandom % 5);
      logic [31:0] d = $urandom;
      case (op)
        0, 1: step(16'(32'h0520 + 8*c), 1'b1, d, "R2 rand");
        2, 3: step(16'(32'h0524 + 8*c), 1'b1, d, "R3 rand");
        4:    step(16'(32'h1520 + 8*c), 1'b0, d, "R6 rand");
        5:    step(16'(32'h0520 + 4*($urandom % 2) + 8*c), 1'b0, d, "R8 rand rd");
        6:    step(16'($urandom), 1'($urandom), d, "R8 rand any");
        default: step(16'(32'h1520 + 8*c), 1'b1, d, "R8 rand stw");
      endcase
    end
    idle(LAT + 1, "R5 drain");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule